// File: doc/BRIEF.md
# Set-Associative Tag Directory with Saturating Age Counters

This block holds only the tag side of a set-associative data cache. It takes at most one access per cycle: a byte address and a read/write flag. For each access it decides whether the access hits or misses. It reports the way that matched, or the way that was refilled on a miss, and it keeps a small saturating age counter for every way, which steers replacement. It does not hold data, fetch from memory or handle write-back. Performance models and cache-sizing studies use it to count hits and misses without a data array.

The address first passes through a translation stage that returns it unchanged. The low bits select the byte within a block, the next bits select the set, and the remaining bits form the tag. On a miss, the tag of the chosen victim way is overwritten. The block keeps four statistics counters: read hits, read misses, write hits and write misses. The number of sets, the block size, the way count and the number of age states are all parameters.

Top module: `tagdir_aging`

## Requirements
- R1: The byte address splits as follows. The low log2(BLOCK_BYTES) bits are the offset and are ignored. The next log2(SETS) bits are the set index, and all higher bits are the tag. Two addresses in the same block therefore behave as the same access.
- R2: Reset clears every tag and every age counter to zero, and there is no valid bit. After reset, an access whose tag is zero hits in the highest-numbered way.
- R3: An access hits when the stored tag of any way in its set equals the access tag. When several ways match, the response reports the highest-numbered matching way.
- R4: On a hit, every nonzero age counter in the set drops by one in the same cycle, and the hit way's counter is set to USTATES-1. The hit way always ends at USTATES-1, even when it was also aged.
- R5: On a miss, the victim is the highest-numbered way whose age counter is below USTATES-1. When no counter is below USTATES-1, the victim is way 0.
- R6: On a miss, the victim's stored tag becomes the access tag. The set's counters are aged as in R4, and the victim's counter is set to USTATES-1.
- R7: Reads (req_write=0) and writes (req_write=1) update tags and counters in the same way. Each access increments exactly one of four 32-bit statistics counters: read hit, read miss, write hit or write miss. Each counter wraps on overflow.
- R8: The response (rsp_valid, rsp_hit, rsp_way) and the updated state appear on the clock edge that samples req_valid=1. A cycle with req_valid=0 leaves tags, counters and statistics unchanged and gives rsp_valid=0 on the next edge.
- R9: rsp_paddr equals the request address of the access it answers, because translation is an identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Byte address (virtual) |
| rsp_valid | output | 1 | Response for the access sampled on the last edge |
| rsp_hit | output | 1 | 1 = hit, 0 = miss |
| rsp_way | output | WAY_W | Way hit or refilled |
| rsp_paddr | output | ADDR_W | Translated (identical) address |
| rd_hit_cnt | output | 32 | Read hit count |
| rd_miss_cnt | output | 32 | Read miss count |
| wr_hit_cnt | output | 32 | Write hit count |
| wr_miss_cnt | output | 32 | Write miss count |

## Verification
Two things can land in the same cycle: the selected way being refreshed to the maximum count, and the same way being aged along with the rest of its set. Back-to-back accesses to one set, some re-touching a way that already sits at a nonzero count, create this collision. The bench's behavioural model then fixes which victim the next miss must choose. Any mistake in ordering the decrement against the refresh shows up a few accesses later as a wrong rsp_way, so every response is compared against the model on every cycle.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

   // Kind of access; only the statistics depend on it.
   typedef enum logic {
      ACC_READ  = 1'b0,
      ACC_WRITE = 1'b1
   } acc_kind_e;

   localparam int STAT_W = 32;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tagdir_xlate.sv
// Address translation stage: identity mapping.
module tagdir_xlate #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] vaddr,
   output logic [ADDR_W-1:0] paddr
);
   assign paddr = vaddr;
endmodule

// File: rtl/tagdir_lookup.sv
// Per-set tag compare, victim choice and age-counter update.
module tagdir_lookup #(
   parameter int WAYS  = 1,
   parameter int TAG_W = 22,
   parameter int CTR_W = 1,
   parameter int WAY_W = 1,
   parameter logic [CTR_W-1:0] CTR_MAX = '1
) (
   input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
   input  logic [WAYS-1:0][CTR_W-1:0] set_ctrs,
   input  logic [TAG_W-1:0]           acc_tag,
   output logic                       hit,
   output logic [WAY_W-1:0]           sel_way,
   output logic [WAYS-1:0][CTR_W-1:0] next_ctrs
);
   logic [WAYS-1:0] match;
   logic [WAYS-1:0] below_max;
   logic [WAY_W-1:0] hit_way;
   logic [WAY_W-1:0] victim_way;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign match[w]     = (set_tags[w] == acc_tag);
      assign below_max[w] = (set_ctrs[w] < CTR_MAX);
   end

   // Highest-numbered candidate wins in both searches.
   always_comb begin
      hit_way    = '0;
      victim_way = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (match[i])     hit_way    = WAY_W'(i);
         if (below_max[i]) victim_way = WAY_W'(i);
      end
   end

   assign hit     = |match;
   assign sel_way = hit ? hit_way : victim_way;

   // Age the set and refresh the selected way in one step.
   always_comb begin
      for (int i = 0; i < WAYS; i++) begin
         if (WAY_W'(i) == sel_way)
            next_ctrs[i] = CTR_MAX;
         else if (set_ctrs[i] != '0)
            next_ctrs[i] = set_ctrs[i] - 1'b1;
         else
            next_ctrs[i] = '0;
      end
   end
endmodule

// File: rtl/tagdir_stats.sv
// Four wrapping event counters: read/write x hit/miss.
module tagdir_stats
   import tagdir_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  acc_kind_e         kind,
   input  logic              hit,
   output logic [STAT_W-1:0] rd_hit,
   output logic [STAT_W-1:0] rd_miss,
   output logic [STAT_W-1:0] wr_hit,
   output logic [STAT_W-1:0] wr_miss
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_hit  <= '0;
         rd_miss <= '0;
         wr_hit  <= '0;
         wr_miss <= '0;
      end else if (fire) begin
         unique case ({kind == ACC_WRITE, hit})
            2'b01:   rd_hit  <= rd_hit  + 1'b1;
            2'b00:   rd_miss <= rd_miss + 1'b1;
            2'b11:   wr_hit  <= wr_hit  + 1'b1;
            default: wr_miss <= wr_miss + 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/tagdir_aging.sv
module tagdir_aging
   import tagdir_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int SETS        = 256,
   parameter int BLOCK_BYTES = 4,
   parameter int WAYS        = 1,
   parameter int USTATES     = 2,
   localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [WAY_W-1:0]  rsp_way,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic [31:0]       rd_hit_cnt,
   output logic [31:0]       rd_miss_cnt,
   output logic [31:0]       wr_hit_cnt,
   output logic [31:0]       wr_miss_cnt
);
   localparam int OFF_W = $clog2(BLOCK_BYTES);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
   localparam int CTR_W = $clog2(USTATES);
   localparam logic [CTR_W-1:0] CTR_MAX = CTR_W'(USTATES - 1);

   // Elaboration-time parameter checks.
   if (!is_pow2(SETS) || SETS < 2) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (!is_pow2(BLOCK_BYTES)) begin : g_bad_block
      $error("BLOCK_BYTES must be a power of two");
   end
   if (WAYS < 1) begin : g_bad_ways
      $error("WAYS must be at least 1");
   end
   if (USTATES < 2) begin : g_bad_states
      $error("USTATES must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for SETS and BLOCK_BYTES");
   end

   logic [ADDR_W-1:0] paddr;
   logic [IDX_W-1:0]  acc_idx;
   logic [TAG_W-1:0]  acc_tag;

   tagdir_xlate #(.ADDR_W(ADDR_W)) u_xlate (
      .vaddr (req_addr),
      .paddr (paddr)
   );

   assign acc_idx = paddr[OFF_W +: IDX_W];
   assign acc_tag = paddr[ADDR_W-1 -: TAG_W];

   logic [WAYS-1:0][TAG_W-1:0] tag_mem [SETS];
   logic [WAYS-1:0][CTR_W-1:0] ctr_mem [SETS];

   logic                       lk_hit;
   logic [WAY_W-1:0]           lk_way;
   logic [WAYS-1:0][CTR_W-1:0] lk_ctrs;

   tagdir_lookup #(
      .WAYS    (WAYS),
      .TAG_W   (TAG_W),
      .CTR_W   (CTR_W),
      .WAY_W   (WAY_W),
      .CTR_MAX (CTR_MAX)
   ) u_lookup (
      .set_tags  (tag_mem[acc_idx]),
      .set_ctrs  (ctr_mem[acc_idx]),
      .acc_tag   (acc_tag),
      .hit       (lk_hit),
      .sel_way   (lk_way),
      .next_ctrs (lk_ctrs)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            tag_mem[s] <= '0;
            ctr_mem[s] <= '0;
         end
      end else if (req_valid) begin
         ctr_mem[acc_idx] <= lk_ctrs;
         if (!lk_hit)
            tag_mem[acc_idx][lk_way] <= acc_tag;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_way   <= '0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_hit   <= lk_hit;
            rsp_way   <= lk_way;
            rsp_paddr <= paddr;
         end
      end
   end

   tagdir_stats u_stats (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (req_valid),
      .kind    (acc_kind_e'(req_write)),
      .hit     (lk_hit),
      .rd_hit  (rd_hit_cnt),
      .rd_miss (rd_miss_cnt),
      .wr_hit  (wr_hit_cnt),
      .wr_miss (wr_miss_cnt)
   );
endmodule

// File: rtl/tagdir_aging_chk.sv
module tagdir_aging_chk #(
   parameter int ADDR_W = 32,
   parameter int WAYS   = 1,
   parameter int WAY_W  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [WAY_W-1:0]  rsp_way,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic [31:0]       rd_hit_cnt,
   input logic [31:0]       rd_miss_cnt,
   input logic [31:0]       wr_hit_cnt,
   input logic [31:0]       wr_miss_cnt
);
   assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_idle_no_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_idle_stats_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rd_hit_cnt) && $stable(rd_miss_cnt)
                      && $stable(wr_hit_cnt) && $stable(wr_miss_cnt)));

   assert_identity_xlate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_paddr == $past(req_addr)));

   assert_way_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (int'(rsp_way) < WAYS));

   assert_read_hit_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=>
         (rsp_hit ? (rd_hit_cnt == $past(rd_hit_cnt) + 32'd1)
                  : (rd_miss_cnt == $past(rd_miss_cnt) + 32'd1)));

   assert_write_hit_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=>
         (rsp_hit ? (wr_hit_cnt == $past(wr_hit_cnt) + 32'd1)
                  : (wr_miss_cnt == $past(wr_miss_cnt) + 32'd1)));

   assert_read_leaves_write_stats_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> ($stable(wr_hit_cnt) && $stable(wr_miss_cnt)));
endmodule

bind tagdir_aging tagdir_aging_chk #(
   .ADDR_W (ADDR_W),
   .WAYS   (WAYS),
   .WAY_W  (WAY_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_write   (req_write),
   .req_addr    (req_addr),
   .rsp_valid   (rsp_valid),
   .rsp_hit     (rsp_hit),
   .rsp_way     (rsp_way),
   .rsp_paddr   (rsp_paddr),
   .rd_hit_cnt  (rd_hit_cnt),
   .rd_miss_cnt (rd_miss_cnt),
   .wr_hit_cnt  (wr_hit_cnt),
   .wr_miss_cnt (wr_miss_cnt)
);

// File: tb/tagdir_aging_test.sv
module tagdir_aging_test;
   localparam int AW   = 16;
   localparam int NS   = 8;
   localparam int BB   = 16;
   localparam int NW   = 4;
   localparam int NU   = 4;
   localparam int MAXC = NU - 1;
   localparam int WW   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid, rsp_hit;
   logic [WW-1:0] rsp_way;
   logic [AW-1:0] rsp_paddr;
   logic [31:0]   rd_hit_cnt, rd_miss_cnt, wr_hit_cnt, wr_miss_cnt;

   always #2 clk = ~clk;

   tagdir_aging #(
      .ADDR_W(AW), .SETS(NS), .BLOCK_BYTES(BB), .WAYS(NW), .USTATES(NU)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_way(rsp_way), .rsp_paddr(rsp_paddr), .rd_hit_cnt(rd_hit_cnt),
      .rd_miss_cnt(rd_miss_cnt), .wr_hit_cnt(wr_hit_cnt), .wr_miss_cnt(wr_miss_cnt)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // Behavioural reference state.
   int mtag [NS][NW];
   int mctr [NS][NW];
   int e_rh = 0, e_rm = 0, e_wh = 0, e_wm = 0;
   int last_hit, last_way;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_stats(input string req);
      chk(req, "rd_hit_cnt",  rd_hit_cnt,  e_rh);
      chk(req, "rd_miss_cnt", rd_miss_cnt, e_rm);
      chk(req, "wr_hit_cnt",  wr_hit_cnt,  e_wh);
      chk(req, "wr_miss_cnt", wr_miss_cnt, e_wm);
   endtask

   // Issue one access at a falling edge; check its response one cycle later.
   task automatic access(input bit wr, input int tg, input int st, input int off);
      logic [AW-1:0] a;
      int hw, sel;
      a = AW'((tg * NS + st) * BB + off);
      hw = -1;
      for (int w = 0; w < NW; w++) if (mtag[st][w] == tg) hw = w;
      if (hw >= 0) sel = hw;
      else begin
         sel = 0;
         for (int w = 0; w < NW; w++) if (mctr[st][w] < MAXC) sel = w;
         mtag[st][sel] = tg;
      end
      for (int w = 0; w < NW; w++) if (mctr[st][w] > 0) mctr[st][w]--;
      mctr[st][sel] = MAXC;
      if (wr) begin if (hw >= 0) e_wh++; else e_wm++; end
      else    begin if (hw >= 0) e_rh++; else e_rm++; end
      last_hit = (hw >= 0);
      last_way = sel;

      req_valid = 1'b1; req_write = wr; req_addr = a;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      chk("R8", "rsp_valid", rsp_valid, 1);
      chk("R3", "rsp_hit", rsp_hit, last_hit);
      chk("R5", "rsp_way", rsp_way, last_way);
      chk("R9", "rsp_paddr", rsp_paddr, a);
      check_stats("R7");
   endtask

   task automatic idle();
      req_valid = 1'b0;
      req_addr  = 16'hFFFF;
      @(posedge clk); @(negedge clk);
      chk("R8", "idle rsp_valid", rsp_valid, 0);
      check_stats("R8");
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin mtag[s][w] = 0; mctr[s][w] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      chk("R2", "reset rsp_valid", rsp_valid, 0);
      check_stats("R2");

      // R2: tag zero hits the top way right after reset
      access(0, 0, 0, 0);
      chk("R2", "tag0 hit", rsp_hit, 1);
      chk("R2", "tag0 way", rsp_way, 3);
      // R5: ages [0,0,0,3] -> victim way 2
      access(0, 5, 0, 0);
      chk("R5", "first victim", rsp_way, 2);
      chk("R6", "miss flag", rsp_hit, 0);
      // R4/R6: ages [0,0,3,2] -> way 3 is below max, taken as victim
      access(1, 6, 0, 4);
      chk("R4", "aged way reused", rsp_way, 3);
      // R1: other offset in the same block of tag 5 hits at way 2
      access(1, 5, 0, 15);
      chk("R1", "offset ignored", rsp_hit, 1);
      chk("R6", "refilled tag kept", rsp_way, 2);
      // R1: same tag in a different set is independent (set 3 holds only zeros)
      access(0, 5, 3, 0);
      chk("R1", "set separation", rsp_hit, 0);
      idle();
      idle();
      // Back-to-back hits on one set: refresh and ageing collide
      access(0, 6, 0, 0);
      access(0, 5, 0, 0);
      access(0, 6, 0, 0);
      access(1, 7, 0, 0);
      chk("R4", "collision victim", rsp_way, last_way);

      // Pseudo-random mix over a small tag pool
      lfsr = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[15:13] == 3'd0) idle();
         else access(lfsr[0], int'(lfsr[4:2]) % 6, int'(lfsr[7:5]), int'(lfsr[11:8]));
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule